// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block watches the processor's instruction address stream and its operand bus, and raises a debug trigger when a programmed condition is seen. Four program-counter comparators and one operand comparator supply the conditions. The operand comparator checks an address against an inclusive window made from a lower and an upper bound register. It can also compare the data, with a per-bit ignore mask, and it can be limited to reads or to writes.

One control register sets how a trigger fires. A single-level trigger fires on its first condition. A two-level trigger is armed by a first condition and fires on a later, second condition. When the trigger fires, the block does one of four things: it pulses a halt request, it pulses a debug interrupt request, it starts trace recording or it stops trace recording.

All registers are 32 bits wide and write-only. They are loaded through a simple address/data write port.

Top module: `bkpt_trig_top`

## Requirements
- R1: Out of reset, halt_req, dbg_irq and trace_en are 0. trig_state is 0 (idle).
- R2: Bit 0 of each PC breakpoint register (address 0..3) is its enable, and it resets to 0. An enabled comparator matches when pc[31:1] equals register bits 31:1 while pc_valid is high.
- R3: Each of the four PC comparators matches on its own address, whatever the other three hold.
- R4: The operand window is inclusive: lower (address 4) ≤ op_addr ≤ upper (address 5). Control bit 4 set inverts this to an outside-window match.
- R5: Control bit 5 enables the data compare against the value register (address 6). Mask register (address 7) bits set to 1 are ignored, and every other bit of op_data must equal the value register.
- R6: Control bits 7:6 qualify the operand direction: 00 or 11 means any, 01 means read only (op_write=0), 10 means write only (op_write=1). A data compare only counts in the same cycle as a valid operand window match of the right direction.
- R7: The control register is at address 8. Bit 1 selects two-level mode. Bit 2 selects the first condition and bit 3 the second (0 means PC, 1 means operand). trig_state is 0 idle, 1 armed, 2 triggered. A single-level trigger goes from idle to triggered. A two-level trigger goes from idle to armed to triggered, and the second condition must arrive in a later cycle. Triggered holds until the control register is rewritten.
- R8: Writing the control register returns trig_state to idle on the next cycle, whatever state it was in. It also cancels any firing in that cycle.
- R9: Control bits 9:8 select the response: 00 halt, 01 debug interrupt, 10 trace start, 11 trace stop. halt_req and dbg_irq are one-cycle pulses that appear in the cycle after the matching bus cycle.
- R10: trace_en goes to 1 on a firing with the trace-start response and to 0 on a firing with the trace-stop response. A control write leaves trace_en unchanged.
- R11: While control bit 0 (trigger enable) is 0, matches have no effect on the outputs or on trig_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| pc | input | 32 | Program counter of the executing instruction |
| pc_valid | input | 1 | pc is valid this cycle |
| op_addr | input | 32 | Operand bus address |
| op_data | input | 32 | Operand bus data |
| op_valid | input | 1 | Operand transfer in this cycle |
| op_write | input | 1 | 1 for a write, 0 for a read |
| halt_req | output | 1 | One-cycle halt request pulse |
| dbg_irq | output | 1 | One-cycle debug interrupt request pulse |
| trace_en | output | 1 | Trace recording enable |
| trig_state | output | 2 | Trigger level: 0 idle, 1 armed, 2 triggered |

## Verification
Some rules are checked by assertions on every cycle:
- The response pulses last one cycle and never occur together.
- A pulse only appears together with the triggered state.
- The state never takes the unused encoding.
- A control write always leads to idle.
- trace_en only moves when the trigger fires.

Other behaviour can only be shown by the bench's scenarios. These are the inclusive window edges in both polarities, the masked data compare, the direction qualifier, the independence of the four PC comparators, and the correct ordering of the two levels. The bench sweeps addresses across the window edges and sweeps data patterns through the mask, and it works out the expected outcome arithmetically.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    RSP_HALT    = 2'd0,
    RSP_IRQ     = 2'd1,
    RSP_TRC_ON  = 2'd2,
    RSP_TRC_OFF = 2'd3
  } rsp_e;

  localparam int CTL_W = 10;

  typedef struct packed {
    logic [1:0] resp;
    logic [1:0] dir;
    logic       data_en;
    logic       outside;
    logic       src2;
    logic       src1;
    logic       two_lvl;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/pc_cmp_bank.sv
module pc_cmp_bank #(
  parameter int NUM = 4,
  parameter int AW  = 32
) (
  input  logic [AW-1:0] pc,
  input  logic          pc_valid,
  input  logic [AW-1:0] bp_q [NUM],
  output logic          hit
);
  logic [NUM-1:0] hit_v;

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    assign hit_v[i] = bp_q[i][0] && (pc[AW-1:1] == bp_q[i][AW-1:1]);
  end

  assign hit = pc_valid && (|hit_v);
endmodule

// File: rtl/op_cmp.sv
module op_cmp #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          op_valid,
  input  logic          op_write,
  input  logic [AW-1:0] lo_q,
  input  logic [AW-1:0] hi_q,
  input  logic [DW-1:0] dval_q,
  input  logic [DW-1:0] dmask_q,
  input  logic          outside,
  input  logic          data_en,
  input  logic [1:0]    dir,
  output logic          hit
);
  logic in_rng, rng_ok, dir_ok, data_ok;

  always_comb begin
    in_rng  = (op_addr >= lo_q) && (op_addr <= hi_q);
    rng_ok  = outside ? !in_rng : in_rng;
    case (dir)
      2'b01:   dir_ok = !op_write;
      2'b10:   dir_ok = op_write;
      default: dir_ok = 1'b1;
    endcase
    data_ok = !data_en || (((op_data ^ dval_q) & ~dmask_q) == '0);
    hit     = op_valid && rng_ok && dir_ok && data_ok;
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  ctl_t       ctl_q,
  input  logic       pc_hit,
  input  logic       op_hit,
  output logic       halt_req,
  output logic       dbg_irq,
  output logic       trace_en,
  output logic [1:0] trig_state
);
  lvl_e st_q, st_d;
  logic fire;
  logic halt_q, halt_d, irq_q, irq_d, trc_q, trc_d;
  logic c1, c2;

  always_comb begin
    c1   = ctl_q.src1 ? op_hit : pc_hit;
    c2   = ctl_q.src2 ? op_hit : pc_hit;
    st_d = st_q;
    fire = 1'b0;
    if (ctl_wr) begin
      st_d = ST_IDLE;
    end else if (ctl_q.en) begin
      case (st_q)
        ST_IDLE: if (c1) begin
          if (ctl_q.two_lvl) begin
            st_d = ST_ARMED;
          end else begin
            st_d = ST_FIRED;
            fire = 1'b1;
          end
        end
        ST_ARMED: if (c2) begin
          st_d = ST_FIRED;
          fire = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
    halt_d = fire && (ctl_q.resp == RSP_HALT);
    irq_d  = fire && (ctl_q.resp == RSP_IRQ);
    trc_d  = trc_q;
    if (fire && (ctl_q.resp == RSP_TRC_ON))  trc_d = 1'b1;
    if (fire && (ctl_q.resp == RSP_TRC_OFF)) trc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      halt_q <= 1'b0;
      irq_q  <= 1'b0;
      trc_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      halt_q <= halt_d;
      irq_q  <= irq_d;
      trc_q  <= trc_d;
    end
  end

  assign halt_req   = halt_q;
  assign dbg_irq    = irq_q;
  assign trace_en   = trc_q;
  assign trig_state = st_q;
endmodule

// File: rtl/bkpt_trig_top.sv
module bkpt_trig_top
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CW     = 32,
  parameter int RA_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RA_W-1:0] cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic [AW-1:0]   pc,
  input  logic            pc_valid,
  input  logic [AW-1:0]   op_addr,
  input  logic [DW-1:0]   op_data,
  input  logic            op_valid,
  input  logic            op_write,
  output logic            halt_req,
  output logic            dbg_irq,
  output logic            trace_en,
  output logic [1:0]      trig_state
);
  localparam logic [RA_W-1:0] A_LO   = RA_W'(NUM_PC);
  localparam logic [RA_W-1:0] A_HI   = RA_W'(NUM_PC + 1);
  localparam logic [RA_W-1:0] A_DVAL = RA_W'(NUM_PC + 2);
  localparam logic [RA_W-1:0] A_DMSK = RA_W'(NUM_PC + 3);
  localparam logic [RA_W-1:0] A_CTL  = RA_W'(NUM_PC + 4);

  logic [AW-1:0] bp_q [NUM_PC];
  logic [AW-1:0] lo_q, hi_q;
  logic [DW-1:0] dval_q, dmask_q;
  ctl_t          ctl_q;
  logic          ctl_wr, pc_hit, op_hit;

  assign ctl_wr = cfg_we && (cfg_addr == A_CTL);

  for (genvar i = 0; i < NUM_PC; i++) begin : g_bp
    logic bp_we;
    assign bp_we = cfg_we && (cfg_addr == RA_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bp_q[i] <= '0;
      else if (bp_we) bp_q[i] <= cfg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      dval_q  <= '0;
      dmask_q <= '0;
      ctl_q   <= '0;
    end else begin
      if (cfg_we && (cfg_addr == A_LO))   lo_q    <= cfg_wdata[AW-1:0];
      if (cfg_we && (cfg_addr == A_HI))   hi_q    <= cfg_wdata[AW-1:0];
      if (cfg_we && (cfg_addr == A_DVAL)) dval_q  <= cfg_wdata[DW-1:0];
      if (cfg_we && (cfg_addr == A_DMSK)) dmask_q <= cfg_wdata[DW-1:0];
      if (ctl_wr)                         ctl_q   <= ctl_t'(cfg_wdata[CTL_W-1:0]);
    end
  end

  pc_cmp_bank #(.NUM(NUM_PC), .AW(AW)) u_pc (
    .pc(pc), .pc_valid(pc_valid), .bp_q(bp_q), .hit(pc_hit)
  );

  op_cmp #(.AW(AW), .DW(DW)) u_op (
    .op_addr(op_addr), .op_data(op_data), .op_valid(op_valid), .op_write(op_write),
    .lo_q(lo_q), .hi_q(hi_q), .dval_q(dval_q), .dmask_q(dmask_q),
    .outside(ctl_q.outside), .data_en(ctl_q.data_en), .dir(ctl_q.dir), .hit(op_hit)
  );

  trig_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_q(ctl_q),
    .pc_hit(pc_hit), .op_hit(op_hit),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .trace_en(trace_en), .trig_state(trig_state)
  );
endmodule

// File: rtl/bkpt_trig_chk.sv
module bkpt_trig_chk #(
  parameter int RA_W  = 4,
  parameter int A_CTL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [RA_W-1:0] cfg_addr,
  input logic            halt_req,
  input logic            dbg_irq,
  input logic            trace_en,
  input logic [1:0]      trig_state
);
  AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq); // R9
  AST_NO_DUAL_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq)); // R9
  AST_PULSE_WHEN_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> (trig_state == 2'd2)); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_state != 2'd3); // R7
  AST_CTL_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == RA_W'(A_CTL))) |=> (trig_state == 2'd0)); // R8
  AST_TRACE_MOVES_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trace_en) |-> (trig_state == 2'd2)); // R10
endmodule

bind bkpt_trig_top bkpt_trig_chk #(.RA_W(RA_W), .A_CTL(NUM_PC + 4)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .halt_req(halt_req), .dbg_irq(dbg_irq), .trace_en(trace_en), .trig_state(trig_state)
);

// File: tb/sim_bkpt_trig_top.sv
module sim_bkpt_trig_top;
  logic        clk, rst_n, cfg_we, pc_valid, op_valid, op_write;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, pc, op_addr, op_data;
  logic        halt_req, dbg_irq, trace_en;
  logic [1:0]  trig_state;
  int checks = 0, fails = 0;

  bkpt_trig_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pc(pc), .pc_valid(pc_valid), .op_addr(op_addr), .op_data(op_data),
    .op_valid(op_valid), .op_write(op_write),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .trace_en(trace_en), .trig_state(trig_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pc_cyc(input logic [31:0] v);
    pc = v; pc_valid = 1'b1;
    @(negedge clk);
    pc_valid = 1'b0;
  endtask

  task automatic op_cyc(input logic [31:0] a, input logic [31:0] d, input logic w);
    op_addr = a; op_data = d; op_write = w; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle1();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pc = '0; pc_valid = 1'b0; op_addr = '0; op_data = '0; op_valid = 1'b0; op_write = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 halt", {31'd0, halt_req}, 0);
    chk("R1 irq", {31'd0, dbg_irq}, 0);
    chk("R1 trace", {31'd0, trace_en}, 0);
    chk("R1 state", {30'd0, trig_state}, 0);
    rst_n = 1'b1;
    idle1();

    // R2: comparators disabled out of reset, pc 0 would equal register value 0
    wr(4'd8, 32'h001);
    pc_cyc(32'h0);
    chk("R2 no match at reset", {31'd0, halt_req}, 0);

    // R3: each comparator alone; R2 bit 0 ignored in compare; R9 pulse; R7 sticky
    for (int i = 0; i < 4; i++) begin
      logic [31:0] base;
      base = 32'h1000 + 32'(i) * 32'h40;
      for (int j = 0; j < 4; j++) wr(4'(j), 32'h0);
      wr(4'(i), base | 32'h1);
      wr(4'd8, 32'h001);
      pc_cyc(base + 32'h2);
      chk("R3 nonmatching pc", {31'd0, halt_req}, 0);
      pc_cyc(base | 32'h1);
      chk("R3 matching pc", {31'd0, halt_req}, 1);
      chk("R7 triggered", {30'd0, trig_state}, 2);
      idle1();
      chk("R9 halt one cycle", {31'd0, halt_req}, 0);
      pc_cyc(base);
      chk("R7 no refire when triggered", {31'd0, halt_req}, 0);
    end

    // R11: trigger disabled
    wr(4'd0, 32'h2001);
    wr(4'd8, 32'h000);
    pc_cyc(32'h2000);
    chk("R11 disabled halt", {31'd0, halt_req}, 0);
    chk("R11 disabled state", {30'd0, trig_state}, 0);

    // R4: inclusive window sweep, inside and outside
    wr(4'd4, 32'h100);
    wr(4'd5, 32'h10F);
    for (int o = 0; o < 2; o++) begin
      for (int a = 32'hFC; a <= 32'h113; a++) begin
        logic exp;
        exp = ((a >= 32'h100) && (a <= 32'h10F)) ^ (o == 1);
        wr(4'd8, (o == 1) ? 32'h115 : 32'h105);
        op_cyc(32'(a), 32'h0, 1'b0);
        chk("R4 window match irq", {31'd0, dbg_irq}, {31'd0, exp});
        chk("R9 no halt on irq response", {31'd0, halt_req}, 0);
      end
    end

    // R5: masked data compare, only bits 7:4 compared against 5
    wr(4'd4, 32'h0);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd6, 32'h50);
    wr(4'd7, 32'hFFFF_FF0F);
    for (int d = 0; d < 256; d++) begin
      logic exp;
      exp = ((d >> 4) & 15) == 5;
      wr(4'd8, 32'h125);
      op_cyc(32'h40, (32'(d) << 24) | 32'(d), 1'b1);
      chk("R5 masked data", {31'd0, dbg_irq}, {31'd0, exp});
    end

    // R6: direction qualifier
    wr(4'd8, 32'h145);
    op_cyc(32'h40, 32'h0, 1'b1);
    chk("R6 read-only ignores write", {31'd0, dbg_irq}, 0);
    op_cyc(32'h40, 32'h0, 1'b0);
    chk("R6 read-only sees read", {31'd0, dbg_irq}, 1);
    wr(4'd8, 32'h185);
    op_cyc(32'h40, 32'h0, 1'b0);
    chk("R6 write-only ignores read", {31'd0, dbg_irq}, 0);
    op_cyc(32'h40, 32'h0, 1'b1);
    chk("R6 write-only sees write", {31'd0, dbg_irq}, 1);

    // R7: two-level, PC arms, operand fires
    wr(4'd4, 32'h100);
    wr(4'd5, 32'h10F);
    wr(4'd8, 32'h10B);
    op_cyc(32'h104, 32'h0, 1'b0);
    chk("R7 second cond before arm", {30'd0, trig_state}, 0);
    chk("R7 no pulse before arm", {31'd0, dbg_irq}, 0);
    pc_cyc(32'h2000);
    chk("R7 armed", {30'd0, trig_state}, 1);
    chk("R7 no pulse on arm", {31'd0, dbg_irq}, 0);
    op_cyc(32'h104, 32'h0, 1'b0);
    chk("R7 fired pulse", {31'd0, dbg_irq}, 1);
    chk("R7 fired state", {30'd0, trig_state}, 2);

    // R8: rewrite while armed returns to idle
    wr(4'd8, 32'h10B);
    pc_cyc(32'h2000);
    chk("R8 armed again", {30'd0, trig_state}, 1);
    wr(4'd8, 32'h10B);
    chk("R8 idle after rewrite", {30'd0, trig_state}, 0);
    op_cyc(32'h104, 32'h0, 1'b0);
    chk("R8 pending arm dropped", {31'd0, dbg_irq}, 0);
    // R8: write in same cycle as a match cancels firing
    wr(4'd8, 32'h001);
    pc = 32'h2000; pc_valid = 1'b1;
    wr(4'd8, 32'h001);
    pc_valid = 1'b0;
    chk("R8 write cancels firing", {31'd0, halt_req}, 0);

    // R10: trace start and stop
    wr(4'd8, 32'h201);
    pc_cyc(32'h2000);
    chk("R10 trace on", {31'd0, trace_en}, 1);
    chk("R10 no halt on trace", {31'd0, halt_req}, 0);
    wr(4'd8, 32'h301);
    chk("R10 trace held over ctl write", {31'd0, trace_en}, 1);
    pc_cyc(32'h2000);
    chk("R10 trace off", {31'd0, trace_en}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule